// File: doc/BRIEF.md
# ALU with Two-Level Operation Decoder

This block is the arithmetic stage of a multi-cycle processor datapath. It is purely combinational. The first level is a decoder. It takes a 2-bit operation class from the sequencer, together with the 6-bit function and 6-bit primary-opcode fields of the current instruction, and reduces them to a 4-bit internal operation code. The second level is a 32-bit ALU. It applies that operation to two operands and a 5-bit shift amount, and it returns the result and a zero flag.

The sequencer uses the operation classes as follows:
- Class 0 forces an addition. It is used for fetch increments and address arithmetic.
- Class 1 forces a subtraction. It is used for branch equality tests.
- Class 2 hands the choice to the function field of register-register instructions.
- Class 3 hands the choice to the primary opcode. Immediate-arithmetic instructions have no function field, so this is how they select an operation.

Operand selection, registers and sequencing sit outside the block.

Top module: `alu_unit`

## Requirements
- R1: With op class 0, result is a + b (mod 2^32) whatever the function, opcode and shift inputs are.
- R2: With op class 1, result is a - b (mod 2^32) whatever the function, opcode and shift inputs are.
- R3: With op class 2, the function values are decoded as: 32 is a + b, 34 is a - b, 36 is a & b, 37 is a | b, 39 is ~(a | b).
- R4: With op class 2 and function 42, result is 1 when a < b as signed two's-complement values, else 0.
- R5: With op class 2, function 0 shifts b left logically by shamt, and function 2 shifts b right logically by shamt, filling with zeros.
- R6: With op class 3, the opcode values are decoded as: 8 is a + b, 10 is the signed set-less-than of a against b (1 or 0), and 15 is {b[15:0], 16'h0000}.
- R7: Any function value not listed in R3 to R5 (op class 2), and any opcode not listed in R6 (op class 3), yields a + b.
- R8: zero is 1 exactly when the 32-bit result is all zeros.
- R9: shamt has no effect on the result of any operation other than the two shifts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_class_i | input | 2 | Operation class from the sequencer (0 add, 1 sub, 2 by function, 3 by opcode) |
| funct_i | input | 6 | Function field of the instruction |
| opcode_i | input | 6 | Primary opcode field of the instruction |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand (register or sign-extended immediate) |
| shamt_i | input | 5 | Shift amount |
| result_o | output | 32 | Operation result |
| zero_o | output | 1 | High when result is zero |

## Verification
The assertions check, on every input change, the rules that hold for every operand value:
- the forced add and subtract classes;
- that the zero flag tracks equality of the operands under subtraction;
- that set-less-than never produces anything but 0 or 1;
- that load-upper leaves the low half clear.

Other properties can only be shown by the bench scenarios, which compare each vector against a behavioural model. These are:
- the exact decode of each function and opcode value;
- the signed-versus-unsigned boundary of set-less-than;
- shifts by 0 and by 31;
- the fallback to addition on unlisted codes;
- the insensitivity to shamt.

// File: rtl/alu_unit_pkg.sv
package alu_unit_pkg;
  localparam int unsigned OP_W    = 4;
  localparam int unsigned FIELD_W = 6;

  typedef enum logic [1:0] {
    CLS_ADD   = 2'd0,
    CLS_SUB   = 2'd1,
    CLS_FUNCT = 2'd2,
    CLS_OPC   = 2'd3
  } op_class_e;

  typedef enum logic [OP_W-1:0] {
    ALU_AND = 4'b0000,
    ALU_OR  = 4'b0001,
    ALU_ADD = 4'b0010,
    ALU_SUB = 4'b0110,
    ALU_SLT = 4'b0111,
    ALU_SLL = 4'b1000,
    ALU_SRL = 4'b1001,
    ALU_LUI = 4'b1010,
    ALU_NOR = 4'b1100
  } alu_op_e;

  // function field values (op class 2)
  localparam logic [FIELD_W-1:0] FN_SLL = 6'd0;
  localparam logic [FIELD_W-1:0] FN_SRL = 6'd2;
  localparam logic [FIELD_W-1:0] FN_ADD = 6'd32;
  localparam logic [FIELD_W-1:0] FN_SUB = 6'd34;
  localparam logic [FIELD_W-1:0] FN_AND = 6'd36;
  localparam logic [FIELD_W-1:0] FN_OR  = 6'd37;
  localparam logic [FIELD_W-1:0] FN_NOR = 6'd39;
  localparam logic [FIELD_W-1:0] FN_SLT = 6'd42;

  // opcode values (op class 3)
  localparam logic [FIELD_W-1:0] OPC_ADDI = 6'd8;
  localparam logic [FIELD_W-1:0] OPC_SLTI = 6'd10;
  localparam logic [FIELD_W-1:0] OPC_LUI  = 6'd15;
endpackage

// File: rtl/alu_op_decoder.sv
module alu_op_decoder
  import alu_unit_pkg::*;
(
  input  logic [1:0]         op_class_i,
  input  logic [FIELD_W-1:0] funct_i,
  input  logic [FIELD_W-1:0] opcode_i,
  output alu_op_e            op_o
);
  alu_op_e funct_op;
  alu_op_e opc_op;

  always_comb begin
    unique case (funct_i)
      FN_SLL:  funct_op = ALU_SLL;
      FN_SRL:  funct_op = ALU_SRL;
      FN_ADD:  funct_op = ALU_ADD;
      FN_SUB:  funct_op = ALU_SUB;
      FN_AND:  funct_op = ALU_AND;
      FN_OR:   funct_op = ALU_OR;
      FN_NOR:  funct_op = ALU_NOR;
      FN_SLT:  funct_op = ALU_SLT;
      default: funct_op = ALU_ADD;
    endcase
  end

  always_comb begin
    unique case (opcode_i)
      OPC_ADDI: opc_op = ALU_ADD;
      OPC_SLTI: opc_op = ALU_SLT;
      OPC_LUI:  opc_op = ALU_LUI;
      default:  opc_op = ALU_ADD;
    endcase
  end

  always_comb begin
    unique case (op_class_e'(op_class_i))
      CLS_ADD:   op_o = ALU_ADD;
      CLS_SUB:   op_o = ALU_SUB;
      CLS_FUNCT: op_o = funct_op;
      CLS_OPC:   op_o = opc_op;
      default:   op_o = ALU_ADD;
    endcase
  end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned SH_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [SH_W-1:0]   amt_i,
  input  logic              right_i,
  output logic [DATA_W-1:0] data_o
);
  // log-depth barrel; right shift done by bit reversal around a left shifter
  logic [DATA_W-1:0] stage [SH_W+1];
  logic [DATA_W-1:0] rev_in;
  logic [DATA_W-1:0] rev_out;

  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign rev_in[i]  = data_i[DATA_W-1-i];
    assign rev_out[i] = stage[SH_W][DATA_W-1-i];
  end

  assign stage[0] = right_i ? rev_in : data_i;

  for (genvar s = 0; s < SH_W; s++) begin : g_stage
    localparam int unsigned STEP = 1 << s;
    assign stage[s+1] = amt_i[s] ? {stage[s][DATA_W-1-STEP:0], {STEP{1'b0}}} : stage[s];
  end

  assign data_o = right_i ? rev_out : stage[SH_W];
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_unit_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned SH_W  = $clog2(DATA_W),
  localparam int unsigned HALF  = DATA_W / 2
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [SH_W-1:0]   shamt_i,
  output logic [DATA_W-1:0] result_o
);
  logic              do_sub;
  logic [DATA_W-1:0] b_eff;
  logic [DATA_W-1:0] sum;
  logic              carry;
  logic              less;
  logic [DATA_W-1:0] shifted;

  // shared adder: subtraction for SUB and SLT
  assign do_sub = (op_i == ALU_SUB) || (op_i == ALU_SLT);
  assign b_eff  = do_sub ? ~b_i : b_i;
  assign {carry, sum} = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, do_sub};

  // signed less-than from adder sign and overflow
  assign less = (a_i[DATA_W-1] ^ b_i[DATA_W-1]) ? a_i[DATA_W-1] : sum[DATA_W-1];

  alu_shifter #(.DATA_W(DATA_W)) u_shift (
    .data_i  (b_i),
    .amt_i   (shamt_i),
    .right_i (op_i == ALU_SRL),
    .data_o  (shifted)
  );

  always_comb begin
    unique case (op_i)
      ALU_AND: result_o = a_i & b_i;
      ALU_OR:  result_o = a_i | b_i;
      ALU_NOR: result_o = ~(a_i | b_i);
      ALU_ADD,
      ALU_SUB: result_o = sum;
      ALU_SLT: result_o = {{(DATA_W-1){1'b0}}, less};
      ALU_SLL,
      ALU_SRL: result_o = shifted;
      ALU_LUI: result_o = {b_i[HALF-1:0], {HALF{1'b0}}};
      default: result_o = sum;
    endcase
  end

  logic unused_carry;
  assign unused_carry = carry;
endmodule

// File: rtl/alu_unit.sv
module alu_unit
  import alu_unit_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned SH_W  = $clog2(DATA_W)
) (
  input  logic [1:0]         op_class_i,
  input  logic [FIELD_W-1:0] funct_i,
  input  logic [FIELD_W-1:0] opcode_i,
  input  logic [DATA_W-1:0]  a_i,
  input  logic [DATA_W-1:0]  b_i,
  input  logic [SH_W-1:0]    shamt_i,
  output logic [DATA_W-1:0]  result_o,
  output logic               zero_o
);
  alu_op_e op;

  alu_op_decoder u_dec (
    .op_class_i (op_class_i),
    .funct_i    (funct_i),
    .opcode_i   (opcode_i),
    .op_o       (op)
  );

  alu_core #(.DATA_W(DATA_W)) u_core (
    .op_i     (op),
    .a_i      (a_i),
    .b_i      (b_i),
    .shamt_i  (shamt_i),
    .result_o (result_o)
  );

  assign zero_o = ~|result_o;
endmodule

// File: rtl/alu_unit_chk.sv
module alu_unit_chk
  import alu_unit_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned HALF  = DATA_W / 2
) (
  input logic [1:0]         op_class_i,
  input logic [FIELD_W-1:0] funct_i,
  input logic [FIELD_W-1:0] opcode_i,
  input logic [DATA_W-1:0]  a_i,
  input logic [DATA_W-1:0]  b_i,
  input logic [DATA_W-1:0]  result_o,
  input logic               zero_o
);
  always_comb begin
    // R1
    force_add_chk: assert (op_class_i != 2'd0 || result_o == a_i + b_i);
    // R2
    force_sub_chk: assert (op_class_i != 2'd1 || result_o == a_i - b_i);
    // R8
    sub_zero_chk: assert (op_class_i != 2'd1 || zero_o == (a_i == b_i));
    // R4
    slt_bool_chk: assert (!(op_class_i == 2'd2 && funct_i == FN_SLT) ||
                          result_o[DATA_W-1:1] == '0);
    // R6
    lui_low_chk: assert (!(op_class_i == 2'd3 && opcode_i == OPC_LUI) ||
                         (result_o[HALF-1:0] == '0 && result_o[DATA_W-1:HALF] == b_i[HALF-1:0]));
  end
endmodule

bind alu_unit alu_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .op_class_i (op_class_i),
  .funct_i    (funct_i),
  .opcode_i   (opcode_i),
  .a_i        (a_i),
  .b_i        (b_i),
  .result_o   (result_o),
  .zero_o     (zero_o)
);

// File: tb/sim_alu_unit.sv
module sim_alu_unit;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  op_class;
  logic [5:0]  funct;
  logic [5:0]  opcode;
  logic [31:0] a, b;
  logic [4:0]  shamt;
  logic [31:0] result;
  logic        zero;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_unit u0 (
    .op_class_i (op_class),
    .funct_i    (funct),
    .opcode_i   (opcode),
    .a_i        (a),
    .b_i        (b),
    .shamt_i    (shamt),
    .result_o   (result),
    .zero_o     (zero)
  );

  function automatic logic [31:0] model(input logic [1:0] c, input logic [5:0] f,
                                        input logic [5:0] o, input logic [31:0] x,
                                        input logic [31:0] y, input logic [4:0] s);
    int sx, sy;
    sx = x; sy = y;
    if (c == 2'd0) return x + y;
    if (c == 2'd1) return x - y;
    if (c == 2'd2) begin
      case (int'(f))
        0:  return y << s;
        2:  return y >> s;
        32: return x + y;
        34: return x - y;
        36: return x & y;
        37: return x | y;
        39: return ~(x | y);
        42: return (sx < sy) ? 32'd1 : 32'd0;
        default: return x + y;
      endcase
    end
    case (int'(o))
      8:  return x + y;
      10: return (sx < sy) ? 32'd1 : 32'd0;
      15: return {y[15:0], 16'h0000};
      default: return x + y;
    endcase
  endfunction

  task automatic apply(input logic [1:0] c, input logic [5:0] f, input logic [5:0] o,
                       input logic [31:0] x, input logic [31:0] y, input logic [4:0] s,
                       input string req);
    logic [31:0] exp_r;
    @(posedge clk);
    op_class = c; funct = f; opcode = o; a = x; b = y; shamt = s;
    exp_r = model(c, f, o, x, y, s);
    @(negedge clk);
    checks++;
    if (result !== exp_r) begin
      errors++;
      $display("FAIL %s result: actual %h expected %h (cls %0d fn %0d opc %0d)",
               req, result, exp_r, c, f, o);
    end
    checks++;
    if (zero !== (exp_r == 32'd0)) begin
      errors++;
      $display("FAIL R8 zero: actual %b expected %b", zero, exp_r == 32'd0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [5:0] fl [11];
    op_class = 0; funct = 0; opcode = 0; a = 0; b = 0; shamt = 0;
    fl = '{6'd0, 6'd2, 6'd32, 6'd34, 6'd36, 6'd37, 6'd39, 6'd42, 6'd1, 6'd33, 6'd63};
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // idle inputs all zero: result 0, zero high (R1, R8)
    checks++;
    if (result !== 32'd0 || zero !== 1'b1) begin
      errors++;
      $display("FAIL R1 idle: actual %h/%b expected 0/1", result, zero);
    end
    // R1 forced add ignores fields
    apply(2'd0, 6'd34, 6'd15, 32'h7fff_ffff, 32'd1, 5'd7, "R1");
    apply(2'd0, 6'd42, 6'd10, 32'hffff_ffff, 32'd1, 5'd0, "R1");
    // R2 forced sub
    apply(2'd1, 6'd32, 6'd8, 32'd5, 32'd5, 5'd3, "R2");
    apply(2'd1, 6'd0, 6'd0, 32'd0, 32'd1, 5'd0, "R2");
    // R3 function decode
    apply(2'd2, 6'd32, 6'd0, 32'd100, 32'd23, 5'd0, "R3");
    apply(2'd2, 6'd34, 6'd0, 32'd100, 32'd123, 5'd0, "R3");
    apply(2'd2, 6'd36, 6'd0, 32'hf0f0_ff00, 32'h0ff0_0f0f, 5'd0, "R3");
    apply(2'd2, 6'd37, 6'd0, 32'hf0f0_0000, 32'h0000_000f, 5'd0, "R3");
    apply(2'd2, 6'd39, 6'd0, 32'hf0f0_0000, 32'h0f0f_ffff, 5'd0, "R3");
    // R4 signed boundary
    apply(2'd2, 6'd42, 6'd0, 32'h8000_0000, 32'h7fff_ffff, 5'd0, "R4");
    apply(2'd2, 6'd42, 6'd0, 32'h7fff_ffff, 32'h8000_0000, 5'd0, "R4");
    apply(2'd2, 6'd42, 6'd0, 32'hffff_ffff, 32'd0, 5'd0, "R4");
    apply(2'd2, 6'd42, 6'd0, 32'd3, 32'd3, 5'd0, "R4");
    // R5 shifts, edges
    apply(2'd2, 6'd0, 6'd0, 32'h0, 32'h8000_0001, 5'd0, "R5");
    apply(2'd2, 6'd0, 6'd0, 32'h0, 32'h8000_0001, 5'd31, "R5");
    apply(2'd2, 6'd2, 6'd0, 32'h0, 32'h8000_0001, 5'd31, "R5");
    apply(2'd2, 6'd2, 6'd0, 32'h0, 32'hf000_0000, 5'd4, "R5");
    // R6 opcode decode
    apply(2'd3, 6'd34, 6'd8, 32'd10, 32'hffff_fffe, 5'd0, "R6");
    apply(2'd3, 6'd0, 6'd10, 32'hffff_fff0, 32'd5, 5'd0, "R6");
    apply(2'd3, 6'd0, 6'd10, 32'd5, 32'hffff_fff0, 5'd0, "R6");
    apply(2'd3, 6'd0, 6'd15, 32'd99, 32'hffff_1234, 5'd9, "R6");
    // R7 unlisted codes fall back to add
    apply(2'd2, 6'd1, 6'd0, 32'd7, 32'd8, 5'd2, "R7");
    apply(2'd2, 6'd63, 6'd0, 32'hffff_ffff, 32'd1, 5'd2, "R7");
    apply(2'd3, 6'd0, 6'd9, 32'd7, 32'd8, 5'd2, "R7");
    apply(2'd3, 6'd0, 6'd35, 32'd1, 32'hffff_ffff, 5'd2, "R7");
    // R9 shamt no effect on non-shift ops
    apply(2'd2, 6'd36, 6'd0, 32'h1234_5678, 32'hffff_0000, 5'd31, "R9");
    apply(2'd3, 6'd0, 6'd15, 32'd0, 32'h0000_abcd, 5'd16, "R9");
    // mixed patterns over all classes
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] c;
      logic [5:0] f, o;
      logic [31:0] x, y;
      c = 2'($urandom_range(0, 3));
      f = fl[$urandom_range(0, 10)];
      o = 6'($urandom_range(0, 16));
      x = (i % 7 == 0) ? 32'h8000_0000 : $urandom;
      y = (i % 5 == 0) ? x : $urandom;
      apply(c, f, o, x, y, 5'($urandom), (c == 2'd3) ? "R6" : (c == 2'd2) ? "R3" : "R1");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule